// File: doc/BRIEF.md
# Single-Cycle Main Instruction Decoder

This block is the main control decoder of a small 16-bit load/store processor that completes one instruction per cycle. The datapath presents the 4-bit opcode taken from bits [15:12] of the current instruction. The decoder drives every datapath control line directly from it:

- register write enable
- destination-register select
- ALU operand-B select
- ALU operation
- memory write enable
- write-back source select
- next-PC source select

No second-level ALU-function decoder exists, because the ALU operation is a direct function of the opcode.

The decoder is purely combinational. An opcode maps first to an instruction class in a classifier stage. A field stage then turns the class into the select lines, and an ALU-map stage turns the class and opcode into the 3-bit ALU operation. The multi-bit selects let the jump-and-link instruction write the return address into register 15. They let jump-register and jump-and-link take different next-PC sources. They also keep shift amounts apart from sign-extended immediates. Opcodes with no assigned instruction decode to a bubble that writes nothing and falls through to the next sequential address.

Opcode map:

| Opcode | Instruction |
|--------|-------------|
| 0x0 | add |
| 0x1 | and |
| 0x2 | or |
| 0x3 | jr |
| 0x4 | nor |
| 0x5 | sub |
| 0x6 | sll |
| 0x7 | srl |
| 0x8 | slt |
| 0x9 | lw |
| 0xA | addi |
| 0xB | sw |
| 0xE | j |
| 0xF | jal |
| 0xC, 0xD | undefined |

Top module: `idec_main`

## Requirements
- R1: `reg_we` is 1 for opcodes 0x0, 0x1, 0x2, 0x4, 0x5, 0x6, 0x7, 0x8, 0x9, 0xA and 0xF. It is 0 for jr (0x3), sw (0xB), j (0xE) and the undefined opcodes.
- R2: `dst_sel` encodes 00 = rt field, 01 = rd field and 10 = register 15. It is 01 for the register-register and shift opcodes (0x0, 0x1, 0x2, 0x4 to 0x8), 10 for jal (0xF), and 00 for every other opcode. The value 11 never appears.
- R3: `bsel` encodes 00 = rt register value, 01 = sign-extended 4-bit immediate and 10 = 4-bit shift amount. It is 10 for sll and srl, 01 for lw, addi and sw, and 00 otherwise. The value 11 never appears.
- R4: `alu_op` encodes 000 and, 001 or, 010 add, 011 sll, 100 nor, 101 srl, 110 sub, 111 slt. Each register-register or shift opcode selects its own operation. lw, addi and sw select add. All other opcodes select 000.
- R5: `mem_we` is 1 only for sw (0xB).
- R6: `wb_sel` encodes 000 = ALU result, 001 = memory read data and 010 = PC+2. It is 001 for lw, 010 for jal, and 000 otherwise.
- R7: `pc_sel` encodes 000 = PC+2, 001 = jump-immediate target and 010 = register target. It is 001 for j and jal, 010 for jr, and 000 otherwise.
- R8: The undefined opcodes 0xC and 0xD drive every output to zero. This gives no register write, no memory write and a sequential next PC.
- R9: The outputs depend only on the present opcode, with no storage. A new opcode is reflected in the same time step, independent of any earlier opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 4 | Instruction bits [15:12] |
| reg_we | output | 1 | Register file write enable |
| dst_sel | output | 2 | Destination register source |
| bsel | output | 2 | ALU operand-B source |
| alu_op | output | 3 | ALU operation |
| mem_we | output | 1 | Data memory write enable |
| wb_sel | output | 3 | Register write-back source |
| pc_sel | output | 3 | Next-PC source |

## Verification
The bench builds the decoder with its default 4-bit opcode width. This makes the full opcode space of sixteen values small enough to sweep exhaustively. The sweep covers both undefined codes and every class boundary. Random opcodes then follow in arbitrary order. This shows that no output depends on the previous opcode, which is how R9 is exercised.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int OPC_W = 4;
    localparam int SEL2_W = 2;
    localparam int SEL3_W = 3;

    typedef enum logic [3:0] {
        CL_ALU_RR,
        CL_SHIFT,
        CL_ADDI,
        CL_LOAD,
        CL_STORE,
        CL_JUMP,
        CL_LINK,
        CL_JREG,
        CL_BUBBLE
    } cls_e;

    typedef enum logic [SEL2_W-1:0] {
        DST_RT   = 2'd0,
        DST_RD   = 2'd1,
        DST_LINK = 2'd2
    } dst_e;

    typedef enum logic [SEL2_W-1:0] {
        BSRC_REG   = 2'd0,
        BSRC_IMM   = 2'd1,
        BSRC_SHAMT = 2'd2
    } bsrc_e;

    typedef enum logic [SEL3_W-1:0] {
        ALU_AND = 3'd0,
        ALU_OR  = 3'd1,
        ALU_ADD = 3'd2,
        ALU_SLL = 3'd3,
        ALU_NOR = 3'd4,
        ALU_SRL = 3'd5,
        ALU_SUB = 3'd6,
        ALU_SLT = 3'd7
    } alu_e;

    typedef enum logic [SEL3_W-1:0] {
        WB_ALU  = 3'd0,
        WB_MEM  = 3'd1,
        WB_LINK = 3'd2
    } wb_e;

    typedef enum logic [SEL3_W-1:0] {
        PCS_SEQ  = 3'd0,
        PCS_IMM  = 3'd1,
        PCS_REG  = 3'd2
    } pcs_e;

    localparam logic [OPC_W-1:0] OPC_ADD  = 4'h0;
    localparam logic [OPC_W-1:0] OPC_AND  = 4'h1;
    localparam logic [OPC_W-1:0] OPC_OR   = 4'h2;
    localparam logic [OPC_W-1:0] OPC_JR   = 4'h3;
    localparam logic [OPC_W-1:0] OPC_NOR  = 4'h4;
    localparam logic [OPC_W-1:0] OPC_SUB  = 4'h5;
    localparam logic [OPC_W-1:0] OPC_SLL  = 4'h6;
    localparam logic [OPC_W-1:0] OPC_SRL  = 4'h7;
    localparam logic [OPC_W-1:0] OPC_SLT  = 4'h8;
    localparam logic [OPC_W-1:0] OPC_LW   = 4'h9;
    localparam logic [OPC_W-1:0] OPC_ADDI = 4'hA;
    localparam logic [OPC_W-1:0] OPC_SW   = 4'hB;
    localparam logic [OPC_W-1:0] OPC_J    = 4'hE;
    localparam logic [OPC_W-1:0] OPC_JAL  = 4'hF;

endpackage

// File: rtl/idec_classify.sv
module idec_classify
    import idec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output cls_e             cls
);

    always_comb begin
        unique case (opcode)
            OPC_ADD, OPC_AND, OPC_OR, OPC_NOR, OPC_SUB, OPC_SLT: cls = CL_ALU_RR;
            OPC_SLL, OPC_SRL: cls = CL_SHIFT;
            OPC_ADDI:         cls = CL_ADDI;
            OPC_LW:           cls = CL_LOAD;
            OPC_SW:           cls = CL_STORE;
            OPC_J:            cls = CL_JUMP;
            OPC_JAL:          cls = CL_LINK;
            OPC_JR:           cls = CL_JREG;
            default:          cls = CL_BUBBLE;
        endcase
    end

endmodule

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
(
    input  cls_e  cls,
    output logic  reg_we,
    output dst_e  dst,
    output bsrc_e bsrc,
    output logic  mem_we,
    output wb_e   wb,
    output pcs_e  pcs
);

    always_comb begin
        // bubble values first: every path leaves all outputs assigned
        reg_we = 1'b0;
        dst    = DST_RT;
        bsrc   = BSRC_REG;
        mem_we = 1'b0;
        wb     = WB_ALU;
        pcs    = PCS_SEQ;
        unique case (cls)
            CL_ALU_RR: begin
                reg_we = 1'b1;
                dst    = DST_RD;
            end
            CL_SHIFT: begin
                reg_we = 1'b1;
                dst    = DST_RD;
                bsrc   = BSRC_SHAMT;
            end
            CL_ADDI: begin
                reg_we = 1'b1;
                bsrc   = BSRC_IMM;
            end
            CL_LOAD: begin
                reg_we = 1'b1;
                bsrc   = BSRC_IMM;
                wb     = WB_MEM;
            end
            CL_STORE: begin
                bsrc   = BSRC_IMM;
                mem_we = 1'b1;
            end
            CL_JUMP: begin
                pcs    = PCS_IMM;
            end
            CL_LINK: begin
                reg_we = 1'b1;
                dst    = DST_LINK;
                wb     = WB_LINK;
                pcs    = PCS_IMM;
            end
            CL_JREG: begin
                pcs    = PCS_REG;
            end
            default: begin
                reg_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/idec_aluop.sv
module idec_aluop
    import idec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  cls_e             cls,
    output alu_e             alu
);

    alu_e rr_op;

    always_comb begin
        unique case (opcode)
            OPC_AND: rr_op = ALU_AND;
            OPC_OR:  rr_op = ALU_OR;
            OPC_NOR: rr_op = ALU_NOR;
            OPC_SUB: rr_op = ALU_SUB;
            OPC_SLT: rr_op = ALU_SLT;
            OPC_SLL: rr_op = ALU_SLL;
            OPC_SRL: rr_op = ALU_SRL;
            default: rr_op = ALU_ADD;
        endcase
    end

    always_comb begin
        unique case (cls)
            CL_ALU_RR, CL_SHIFT:         alu = rr_op;
            CL_ADDI, CL_LOAD, CL_STORE:  alu = ALU_ADD;
            default:                     alu = ALU_AND;
        endcase
    end

endmodule

// File: rtl/idec_main.sv
module idec_main
    import idec_pkg::*;
#(
    parameter int OPW = OPC_W,
    parameter int S2W = SEL2_W,
    parameter int S3W = SEL3_W
) (
    input  logic [OPW-1:0] opcode,
    output logic           reg_we,
    output logic [S2W-1:0] dst_sel,
    output logic [S2W-1:0] bsel,
    output logic [S3W-1:0] alu_op,
    output logic           mem_we,
    output logic [S3W-1:0] wb_sel,
    output logic [S3W-1:0] pc_sel
);

    cls_e  cls;
    dst_e  dst;
    bsrc_e bsrc;
    alu_e  alu;
    wb_e   wb;
    pcs_e  pcs;

    idec_classify u_classify (
        .opcode (opcode),
        .cls    (cls)
    );

    idec_fields u_fields (
        .cls    (cls),
        .reg_we (reg_we),
        .dst    (dst),
        .bsrc   (bsrc),
        .mem_we (mem_we),
        .wb     (wb),
        .pcs    (pcs)
    );

    idec_aluop u_aluop (
        .opcode (opcode),
        .cls    (cls),
        .alu    (alu)
    );

    assign dst_sel = dst;
    assign bsel    = bsrc;
    assign alu_op  = alu;
    assign wb_sel  = wb;
    assign pc_sel  = pcs;

endmodule

// File: rtl/idec_chk.sv
module idec_chk (
    input logic [3:0] opcode,
    input logic       reg_we,
    input logic [1:0] dst_sel,
    input logic [1:0] bsel,
    input logic [2:0] alu_op,
    input logic       mem_we,
    input logic [2:0] wb_sel,
    input logic [2:0] pc_sel
);

    always_comb begin
        AST_WB_NEEDS_WRITE: assert (wb_sel == 3'd0 || reg_we) else $error("write-back source set without write"); // R1
        AST_LINK_DST_PAIRED: assert (dst_sel != 2'd2 || (wb_sel == 3'd2 && pc_sel == 3'd1)) else $error("r15 target without link"); // R2
        AST_DST_LEGAL: assert (dst_sel != 2'd3) else $error("reserved dst select"); // R2
        AST_SHAMT_ONLY_SHIFT: assert (bsel != 2'd2 || alu_op == 3'd3 || alu_op == 3'd5) else $error("shift amount without shift"); // R3
        AST_BSEL_LEGAL: assert (bsel != 2'd3) else $error("reserved operand-B select"); // R3
        AST_IMM_ADDS: assert (bsel != 2'd1 || alu_op == 3'd2) else $error("immediate without add"); // R4
        AST_STORE_NO_REGWR: assert (!mem_we || (!reg_we && bsel == 2'd1)) else $error("store writes register"); // R5
        AST_MEM_WB_LOADS: assert (wb_sel != 3'd1 || (reg_we && !mem_we)) else $error("memory write-back off a load"); // R6
        AST_JREG_NO_WRITE: assert (pc_sel != 3'd2 || !reg_we) else $error("register jump writes"); // R7
        AST_BUBBLE_QUIET: assert (!(opcode == 4'hC || opcode == 4'hD) || (!reg_we && !mem_we && pc_sel == 3'd0)) else $error("undefined opcode not a bubble"); // R8
    end

endmodule

bind idec_main idec_chk u_chk (.*);

// File: tb/tb_idec_main.sv
module tb_idec_main;

    logic       clk;
    logic [3:0] opcode;
    logic       reg_we;
    logic [1:0] dst_sel;
    logic [1:0] bsel;
    logic [2:0] alu_op;
    logic       mem_we;
    logic [2:0] wb_sel;
    logic [2:0] pc_sel;

    int vectors = 0;
    int miscompares = 0;
    int checks = 0;

    idec_main dut (
        .opcode (opcode),
        .reg_we (reg_we),
        .dst_sel(dst_sel),
        .bsel   (bsel),
        .alu_op (alu_op),
        .mem_we (mem_we),
        .wb_sel (wb_sel),
        .pc_sel (pc_sel)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // R1
    function automatic logic e_we(input logic [3:0] op);
        return op inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hF};
    endfunction

    // R2
    function automatic logic [1:0] e_dst(input logic [3:0] op);
        if (op inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8}) return 2'd1;
        if (op == 4'hF) return 2'd2;
        return 2'd0;
    endfunction

    // R3
    function automatic logic [1:0] e_bsel(input logic [3:0] op);
        if (op inside {4'h6, 4'h7}) return 2'd2;
        if (op inside {4'h9, 4'hA, 4'hB}) return 2'd1;
        return 2'd0;
    endfunction

    // R4
    function automatic logic [2:0] e_alu(input logic [3:0] op);
        case (op)
            4'h0, 4'h9, 4'hA, 4'hB: return 3'd2;
            4'h1: return 3'd0;
            4'h2: return 3'd1;
            4'h4: return 3'd4;
            4'h5: return 3'd6;
            4'h6: return 3'd3;
            4'h7: return 3'd5;
            4'h8: return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

    // R6
    function automatic logic [2:0] e_wb(input logic [3:0] op);
        if (op == 4'h9) return 3'd1;
        if (op == 4'hF) return 3'd2;
        return 3'd0;
    endfunction

    // R7
    function automatic logic [2:0] e_pc(input logic [3:0] op);
        if (op inside {4'hE, 4'hF}) return 3'd1;
        if (op == 4'h3) return 3'd2;
        return 3'd0;
    endfunction

    task automatic cmp(input string tag, input int act, input int exp, input logic [3:0] op);
        checks++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s opcode=%h actual=%0d expected=%0d", tag, op, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op);
        @(negedge clk);
        opcode = op;
        #1;
        vectors++;
        cmp("R1 reg_we", int'(reg_we),  int'(e_we(op)),  op);
        cmp("R2 dst_sel", int'(dst_sel), int'(e_dst(op)), op);
        cmp("R3 bsel",   int'(bsel),    int'(e_bsel(op)), op);
        cmp("R4 alu_op", int'(alu_op),  int'(e_alu(op)), op);
        cmp("R5 mem_we", int'(mem_we),  (op == 4'hB) ? 1 : 0, op);
        cmp("R6 wb_sel", int'(wb_sel),  int'(e_wb(op)),  op);
        cmp("R7 pc_sel", int'(pc_sel),  int'(e_pc(op)),  op);
        if (op == 4'hC || op == 4'hD)
            cmp("R8 bubble", int'({reg_we, dst_sel, bsel, alu_op, mem_we, wb_sel, pc_sel}), 0, op);
    endtask

    initial begin
        #(20 * 150000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [3:0] prev;
        void'($urandom(32'h1d3c));
        opcode = 4'h0;
        // exhaustive directed sweep, including undefined 0xC/0xD (R8)
        for (int i = 0; i < 16; i++) apply(4'(i));
        // R8 bubble right after a link and after a store
        apply(4'hF); apply(4'hC);
        apply(4'hB); apply(4'hD);
        // R9 random order: result independent of the previous opcode
        prev = 4'h0;
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            apply(op);
            if (op == prev) apply(~op);
            prev = op;
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule